// File: doc/BRIEF.md
# Hot-Plug Slot Power, Clock and Reset Sequencer

This block drives the sideband lines of one downstream hot-plug slot. It powers the slot only when a card is present and software has enabled power. It turns on the reference clock only after the supply reports good. It holds the card in reset for a programmable settling time with the clock running, and then releases it. If the card is pulled out, power is disabled by software, or power-good drops, the clock and reset are withdrawn in the same cycle the filtered condition is seen.

The card-present line passes through a two-flop synchronizer and a debouncer, so a level must hold for a set number of cycles before it counts. Each accepted change of presence sets a sticky status flag that software clears by writing one. Power-good is synchronized but not debounced. During normal operation a clock-request input from the card gates the reference clock. A port-activity strobe blinks an activity LED.

Top module: `hp_slot_seq`

## Requirements
- R1: While reset is asserted and directly after it, slot_pwr_n=1, card_rst_n=0, refclk_en=0, act_led=1 and pdc_flag=0.
- R2: card_here_n (low = card attached) is synchronized by two flops and accepted only after the synchronized level differs from the accepted one for DEB_LEN (default 16) consecutive cycles. A pulse shorter than that has no effect on any output.
- R3: While the accepted presence says no card, slot_pwr_n=1, card_rst_n=0 and refclk_en=0.
- R4: With a card present and sw_pwr_en=1, slot_pwr_n goes low. refclk_en stays 0 and card_rst_n stays 0 until synchronized pwr_good is 1.
- R5: One cycle after synchronized pwr_good reads 1, refclk_en rises. card_rst_n is held low for RST_WAIT (default 100) further cycles and then goes high.
- R6: When pwr_good falls, card_rst_n=0 and refclk_en=0 within three clock edges, while slot_pwr_n stays low.
- R7: Once the card is out of reset, refclk_en equals the inverse of clkreq_n. While the slot is unpowered, absent or not power-good, or during the reset countdown, clkreq_n has no effect.
- R8: Each cycle with act_pulse=1 inverts act_led on the next edge. After ACT_IDLE (default 8) cycles without a pulse, act_led returns to 1.
- R9: Every accepted presence change sets pdc_flag. pdc_clr=1 clears it. A presence change in the same cycle as a clear leaves the flag set.
- R10: Clearing sw_pwr_en drives slot_pwr_n=1, card_rst_n=0 and refclk_en=0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_here_n | input | 1 | Card presence, low = attached (asynchronous) |
| pwr_good | input | 1 | Slot supply good, high = good (asynchronous) |
| clkreq_n | input | 1 | Card clock request, low = clock wanted |
| act_pulse | input | 1 | One-cycle port activity strobe |
| sw_pwr_en | input | 1 | Software power enable |
| pdc_clr | input | 1 | Write-one-to-clear for pdc_flag |
| slot_pwr_n | output | 1 | Slot power on, low = powered |
| card_rst_n | output | 1 | Card reset, low = held in reset |
| refclk_en | output | 1 | Reference clock enable |
| act_led | output | 1 | Activity LED, rests high |
| pdc_flag | output | 1 | Presence-detect-changed status |

## Verification
A sequencer stuck in the wrong state shows at the ports within a few cycles. Reset might release before the settling count ends. The clock might stay on after power-good loss. Power might stay on after removal. Each of these conditions is sampled a fixed number of edges after the stimulus. A debouncer with the wrong length shows as pdc_flag changing early or on a short glitch, so the flag is checked both before and after the expected acceptance edge. A wrong set/clear priority in the status flag shows only when a clear lands on the acceptance edge, and that edge is hit on purpose.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_PWR, ST_CLK, ST_UP} slot_st_e;

  // reference clock: always on during settling, request-gated once out of reset
  function automatic logic f_clk_on(slot_st_e st, logic live, logic clkreq_n);
    return live && ((st == ST_CLK) || ((st == ST_UP) && !clkreq_n));
  endfunction

  // debounce acceptance: level differs and the run has reached its length
  function automatic logic f_deb_done(logic differs, int unsigned cnt, int unsigned len);
    return differs && (cnt == len - 1);
  endfunction
endpackage

// File: rtl/hp_sync_filt.sv
module hp_sync_filt #(
  parameter int unsigned DEB_LEN = 16,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic chg
);
  import hp_slot_pkg::*;
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s1 <= din;
      s2 <= s1;
    end
  end

  generate
    if (DEB_LEN <= 1) begin : g_plain
      assign level = s2;
      assign chg   = 1'b0;
    end else begin : g_deb
      localparam int CW = $clog2(DEB_LEN + 1);
      logic [CW-1:0] cnt;
      logic          acc;
      logic          differs;
      assign differs = (s2 != acc);
      assign chg     = f_deb_done(differs, int'(cnt), DEB_LEN);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc <= RST_VAL;
          cnt <= '0;
        end else if (!differs) begin
          cnt <= '0;
        end else if (chg) begin
          acc <= s2;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign level = acc;

      a_r2_accept_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc) |-> $past(cnt) == CW'(DEB_LEN - 1));
    end
  endgenerate
endmodule

// File: rtl/hp_pwr_fsm.sv
module hp_pwr_fsm #(
  parameter int unsigned RST_WAIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  input  logic pgood,
  input  logic sw_en,
  input  logic clkreq_n,
  output logic slot_pwr_n,
  output logic card_rst_n,
  output logic refclk_en
);
  import hp_slot_pkg::*;
  localparam int CW = $clog2(RST_WAIT + 1);

  slot_st_e      st, st_nx;
  logic [CW-1:0] cnt;
  logic          keep_pwr, live, wait_done;

  assign keep_pwr  = present && sw_en;
  assign live      = keep_pwr && pgood;
  assign wait_done = (cnt == CW'(RST_WAIT - 1));

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_OFF: if (keep_pwr) st_nx = ST_PWR;
      ST_PWR: if (!keep_pwr) st_nx = ST_OFF;
              else if (pgood) st_nx = ST_CLK;
      ST_CLK: if (!keep_pwr) st_nx = ST_OFF;
              else if (!pgood) st_nx = ST_PWR;
              else if (wait_done) st_nx = ST_UP;
      ST_UP:  if (!keep_pwr) st_nx = ST_OFF;
              else if (!pgood) st_nx = ST_PWR;
      default: st_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= (st == ST_CLK && st_nx == ST_CLK) ? cnt + 1'b1 : '0;
    end
  end

  assign slot_pwr_n = !((st != ST_OFF) && keep_pwr);
  assign card_rst_n = (st == ST_UP) && live;
  assign refclk_en  = f_clk_on(st, live, clkreq_n);

  a_r4_release_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst_n |-> !slot_pwr_n && pgood);
  a_r5_clock_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst_n) |-> $past(refclk_en));
  a_r3_absent_off: assert property (@(posedge clk) disable iff (!rst_n)
    !present |-> slot_pwr_n && !card_rst_n && !refclk_en);
endmodule

// File: rtl/hp_act_led.sv
module hp_act_led #(
  parameter int unsigned ACT_IDLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic led
);
  localparam int CW = $clog2(ACT_IDLE + 1);
  logic [CW-1:0] idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led  <= 1'b1;
      idle <= '0;
    end else if (pulse) begin
      led  <= !led;
      idle <= '0;
    end else if (idle == CW'(ACT_IDLE - 1)) begin
      led  <= 1'b1;
    end else begin
      idle <= idle + 1'b1;
    end
  end

  a_r8_led_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> led != $past(led));
endmodule

// File: rtl/hp_slot_seq.sv
module hp_slot_seq #(
  parameter int unsigned DEB_LEN  = 16,
  parameter int unsigned RST_WAIT = 100,
  parameter int unsigned ACT_IDLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_here_n,
  input  logic pwr_good,
  input  logic clkreq_n,
  input  logic act_pulse,
  input  logic sw_pwr_en,
  input  logic pdc_clr,
  output logic slot_pwr_n,
  output logic card_rst_n,
  output logic refclk_en,
  output logic act_led,
  output logic pdc_flag
);
  logic here_n_acc, pres_chg, pgood_s, pg_unused;

  hp_sync_filt #(.DEB_LEN(DEB_LEN), .RST_VAL(1'b1)) u_pres (
    .clk(clk), .rst_n(rst_n), .din(card_here_n), .level(here_n_acc), .chg(pres_chg));

  hp_sync_filt #(.DEB_LEN(1), .RST_VAL(1'b0)) u_pgood (
    .clk(clk), .rst_n(rst_n), .din(pwr_good), .level(pgood_s), .chg(pg_unused));

  hp_pwr_fsm #(.RST_WAIT(RST_WAIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .present(!here_n_acc), .pgood(pgood_s),
    .sw_en(sw_pwr_en), .clkreq_n(clkreq_n), .slot_pwr_n(slot_pwr_n),
    .card_rst_n(card_rst_n), .refclk_en(refclk_en));

  hp_act_led #(.ACT_IDLE(ACT_IDLE)) u_led (
    .clk(clk), .rst_n(rst_n), .pulse(act_pulse), .led(act_led));

  // sticky presence-change flag, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pdc_flag <= 1'b0;
    else if (pres_chg) pdc_flag <= 1'b1;
    else if (pdc_clr)  pdc_flag <= 1'b0;
  end

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pdc_flag && !pdc_clr |=> pdc_flag);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pres_chg |=> pdc_flag);
  a_r10_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_pwr_en |-> slot_pwr_n && !card_rst_n);
endmodule

// File: tb/hp_slot_seq_test.sv
module hp_slot_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic card_here_n = 1'b1, pwr_good = 1'b0, clkreq_n = 1'b1;
  logic act_pulse = 1'b0, sw_pwr_en = 1'b0, pdc_clr = 1'b0;
  logic slot_pwr_n, card_rst_n, refclk_en, act_led, pdc_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  hp_slot_seq uut (.*);

  // {sw_en, pgood, clkreq_n, exp slot_pwr_n, exp refclk_en, exp card_rst_n}
  localparam logic [5:0] VEC [5] = '{
    6'b110_011, 6'b111_001, 6'b100_000, 6'b010_100, 6'b110_011};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic led_pulse();
    act_pulse = 1'b1; wait_n(1); act_pulse = 1'b0;
  endtask

  initial begin
    wait_n(3);
    check("R1 slot_pwr_n", slot_pwr_n, 1); check("R1 card_rst_n", card_rst_n, 0);
    check("R1 refclk_en", refclk_en, 0); check("R1 act_led", act_led, 1);
    check("R1 pdc_flag", pdc_flag, 0);
    rst_n = 1'b1; wait_n(2);
    check("R1 after release", {slot_pwr_n, card_rst_n, refclk_en, act_led, pdc_flag}, 5'b10010);

    // insertion: accepted on the 18th edge
    card_here_n = 1'b0; wait_n(14);
    check("R2 not yet accepted", pdc_flag, 0);
    wait_n(8);
    check("R9 set on insert", pdc_flag, 1);
    pdc_clr = 1'b1; wait_n(1); pdc_clr = 1'b0;
    check("R9 cleared", pdc_flag, 0);
    // short glitch ignored
    card_here_n = 1'b1; wait_n(8); card_here_n = 1'b0; wait_n(30);
    check("R2 glitch no flag", pdc_flag, 0);

    // power up sequence
    sw_pwr_en = 1'b1; wait_n(5);
    check("R4 powered no pgood", {slot_pwr_n, refclk_en, card_rst_n}, 3'b000);
    pwr_good = 1'b1; wait_n(10);
    check("R5 clock during wait", refclk_en, 1);
    check("R7 clkreq ignored in wait", card_rst_n, 0);
    wait_n(85);
    check("R5 still in reset", card_rst_n, 0);
    wait_n(15);
    check("R5 released", card_rst_n, 1);
    check("R7 clkreq high gates", refclk_en, 0);

    // table walk
    foreach (VEC[i]) begin
      sw_pwr_en = VEC[i][5]; pwr_good = VEC[i][4]; clkreq_n = VEC[i][3];
      wait_n(120);
      check($sformatf("R7 R10 R6 vector %0d", i),
            {slot_pwr_n, refclk_en, card_rst_n}, {29'd0, VEC[i][2:0]});
    end

    // power-good loss: reset and clock off within three edges
    pwr_good = 1'b0; wait_n(3);
    check("R6 pgood loss", {slot_pwr_n, refclk_en, card_rst_n}, 3'b000);
    pwr_good = 1'b1; wait_n(120);
    check("R6 recovered", card_rst_n, 1);

    // removal
    card_here_n = 1'b1; wait_n(25);
    check("R3 removed", {slot_pwr_n, refclk_en, card_rst_n}, 3'b100);
    check("R9 set on removal", pdc_flag, 1);
    clkreq_n = 1'b0; wait_n(3);
    check("R7 clkreq ignored when absent", refclk_en, 0);

    // clear colliding with acceptance edge
    pdc_clr = 1'b1; wait_n(1); pdc_clr = 1'b0;
    check("R9 cleared again", pdc_flag, 0);
    card_here_n = 1'b0; wait_n(17);
    pdc_clr = 1'b1; wait_n(1); pdc_clr = 1'b0;
    check("R9 set wins over clear", pdc_flag, 1);

    // activity LED
    led_pulse(); check("R8 first toggle", act_led, 0);
    led_pulse(); check("R8 second toggle", act_led, 1);
    led_pulse(); check("R8 third toggle", act_led, 0);
    wait_n(4);  check("R8 held before idle", act_led, 0);
    wait_n(8);  check("R8 rests high", act_led, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule